// File: doc/BRIEF.md
# Clock Synchronization State Controller

This block decides the synchronization state of a time-triggered Ethernet clock synchronization engine. Logic elsewhere counts the clock masters that were seen inside their schedule and outside it during each acceptance window. At the end of every window that logic hands the two counts to this block with a one-cycle strobe. The block compares the counts against programmable thresholds. It keeps two run-length counters: consecutive supported windows while in SYNC, and consecutive low-support windows while in STABLE. From these it moves between four states and reports the current state together with a one-cycle change strobe.

All decisions are taken only on the window-end strobe, and only while the block is enabled. When the enable input is deasserted, the block returns to UNSYNC and empties both run counters. The two cycle limits treat zero as "move on the first qualifying window". A window that breaks a run, or any change of state, clears both counters.

Top module: `clksync_state`

## Requirements
- R1: During reset, and in the cycle after any clock edge at which `enable` is low, `state` is UNSYNC and `stateChg` is low. Both run counters are cleared. The state encoding on the `state` port is 0 = UNSYNC, 1 = INTEGRATE, 2 = SYNC, 3 = STABLE.
- R2: `state` changes only at a clock edge where `winEnd` and `enable` are both high.
- R3: From UNSYNC, the first window end moves to INTEGRATE.
- R4: In INTEGRATE, a window end with `inSchedCnt >= syncTh` moves to SYNC. Otherwise the state stays INTEGRATE.
- R5: In SYNC, a window end with `outSchedCnt >= syncExitTh` leaves SYNC. The target is UNSYNC when `exitToUnsync` is 1 and INTEGRATE when it is 0. This check is evaluated before any support check.
- R6: In SYNC, a window with `inSchedCnt >= syncTh` is supported. If `stableEn` is 1 and the number of preceding consecutive supported windows in SYNC is at least `supLimit`, the state moves to STABLE. With `supLimit` = 0, this happens on the first supported window. Otherwise the run count grows by one, saturating at its maximum.
- R7: While `stableEn` is 0, SYNC never moves to STABLE. Supported windows still leave the state at SYNC.
- R8: In SYNC, a window without support (and without exit) keeps SYNC and restarts the supported run from zero.
- R9: In STABLE, a window end with `outSchedCnt >= stableExitTh` moves to INTEGRATE. This check is evaluated before any low-support check.
- R10: In STABLE, a window with `inSchedCnt < stableTh` is a low-support window. If the number of preceding consecutive low-support windows is at least `lowLimit`, the state moves to INTEGRATE. With `lowLimit` = 0, this happens on the first such window. Otherwise the state stays STABLE and the run grows by one.
- R11: In STABLE, a window with `inSchedCnt >= stableTh` keeps STABLE and restarts the low-support run from zero.
- R12: `stateChg` is high for exactly the one cycle after a window end that changed the state. It is low in every other cycle.
- R13: Every change of state clears both run counters. A later return to SYNC therefore needs a complete new supported run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Engine enable; low forces UNSYNC |
| winEnd | input | 1 | One-cycle acceptance-window-end strobe |
| inSchedCnt | input | CNT_W | In-schedule clock masters of the ending window |
| outSchedCnt | input | CNT_W | Out-of-schedule clock masters of the ending window |
| syncTh | input | CNT_W | Support threshold for INTEGRATE entry and SYNC runs |
| syncExitTh | input | CNT_W | Out-of-schedule threshold for leaving SYNC |
| stableExitTh | input | CNT_W | Out-of-schedule threshold for leaving STABLE |
| stableTh | input | CNT_W | In-schedule threshold below which STABLE is low-support |
| supLimit | input | CYC_W | Supported windows needed before SYNC to STABLE |
| lowLimit | input | CYC_W | Low-support windows tolerated in STABLE |
| stableEn | input | 1 | Permits the SYNC to STABLE move |
| exitToUnsync | input | 1 | Target of a SYNC exit: 1 UNSYNC, 0 INTEGRATE |
| state | output | 2 | Current state (0 UNSYNC, 1 INTEGRATE, 2 SYNC, 3 STABLE) |
| stateChg | output | 1 | One-cycle strobe after a state change |

## Verification
Directed sequences first walk through every transition. They include a broken supported run and a broken low run, which tell counter restart apart from counter hold. They also include a re-entry into SYNC, which separates clearing on a state change from clearing on a break. A sweep then covers both exit targets, both settings of the stable enable, and cycle limits of 0, 1 and 2. In each configuration it drives pseudo-random count pairs biased around the thresholds. The zero-limit cases expose off-by-one errors in the run comparison, and the high out-of-schedule counts expose wrong priority between the exit and support decisions. An idle cycle after every window and an enable drop before each configuration confirm that nothing moves without a window end.

// File: rtl/clksync_pkg.sv
package clksync_pkg;

  typedef enum logic [1:0] {
    ST_UNSYNC = 2'd0,
    ST_INTEG  = 2'd1,
    ST_SYNC   = 2'd2,
    ST_STABLE = 2'd3
  } syncState_t;

  // strobes from control to the run counters
  typedef struct packed {
    logic supInc;
    logic lowInc;
    logic cntClr;
  } cntCtrl_t;

endpackage

// File: rtl/clksync_dp.sv
module clksync_dp
  import clksync_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int CYC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctrl,
  input  logic [CNT_W-1:0] inSchedCnt,
  input  logic [CNT_W-1:0] outSchedCnt,
  input  logic [CNT_W-1:0] syncTh,
  input  logic [CNT_W-1:0] syncExitTh,
  input  logic [CNT_W-1:0] stableExitTh,
  input  logic [CNT_W-1:0] stableTh,
  input  logic [CYC_W-1:0] supLimit,
  input  logic [CYC_W-1:0] lowLimit,
  output logic             syncSupport,
  output logic             stableLow,
  output logic             syncExitHit,
  output logic             stableExitHit,
  output logic             supDone,
  output logic             lowDone,
  output logic [CYC_W-1:0] supRun,
  output logic [CYC_W-1:0] lowRun
);

  localparam logic [CYC_W-1:0] RUN_MAX = {CYC_W{1'b1}};

  // threshold comparisons on the window counts
  always_comb begin
    syncSupport   = (inSchedCnt >= syncTh);
    stableLow     = (inSchedCnt < stableTh);
    syncExitHit   = (outSchedCnt >= syncExitTh);
    stableExitHit = (outSchedCnt >= stableExitTh);
  end

  // run length reached: zero limit means the first qualifying window
  always_comb begin
    supDone = (supRun >= supLimit);
    lowDone = (lowRun >= lowLimit);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.cntClr) begin
      supRun <= '0;
    end else if (ctrl.supInc && (supRun != RUN_MAX)) begin
      supRun <= supRun + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.cntClr) begin
      lowRun <= '0;
    end else if (ctrl.lowInc && (lowRun != RUN_MAX)) begin
      lowRun <= lowRun + 1'b1;
    end
  end

  AST_SUP_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (supRun == RUN_MAX) |=> (supRun == RUN_MAX || supRun == '0)); // R6
  AST_LOW_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (lowRun == RUN_MAX) |=> (lowRun == RUN_MAX || lowRun == '0)); // R10
  AST_ONE_RUN_AT_A_TIME: assert property (@(posedge clk) disable iff (!rstN)
    !(supRun != '0 && lowRun != '0)); // R13

endmodule

// File: rtl/clksync_fsm.sv
module clksync_fsm
  import clksync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       winEnd,
  input  logic       stableEn,
  input  logic       exitToUnsync,
  input  logic       syncSupport,
  input  logic       stableLow,
  input  logic       syncExitHit,
  input  logic       stableExitHit,
  input  logic       supDone,
  input  logic       lowDone,
  output syncState_t state,
  output logic       stateChg,
  output cntCtrl_t   ctrl
);

  syncState_t nextState;
  logic       runBreak;

  always_comb begin
    nextState = state;
    runBreak  = 1'b0;
    ctrl.supInc = 1'b0;
    ctrl.lowInc = 1'b0;
    if (!enable) begin
      nextState = ST_UNSYNC;
      runBreak  = 1'b1;
    end else if (winEnd) begin
      unique case (state)
        ST_UNSYNC: nextState = ST_INTEG;
        ST_INTEG: begin
          if (syncSupport) nextState = ST_SYNC;
        end
        ST_SYNC: begin
          if (syncExitHit) begin
            nextState = exitToUnsync ? ST_UNSYNC : ST_INTEG;
          end else if (syncSupport) begin
            if (stableEn && supDone) nextState = ST_STABLE;
            else ctrl.supInc = 1'b1;
          end else begin
            runBreak = 1'b1;
          end
        end
        ST_STABLE: begin
          if (stableExitHit) begin
            nextState = ST_INTEG;
          end else if (stableLow) begin
            if (lowDone) nextState = ST_INTEG;
            else ctrl.lowInc = 1'b1;
          end else begin
            runBreak = 1'b1;
          end
        end
        default: nextState = ST_UNSYNC;
      endcase
    end
    ctrl.cntClr = runBreak || (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_UNSYNC;
      stateChg <= 1'b0;
    end else begin
      state    <= nextState;
      stateChg <= enable && winEnd && (nextState != state);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !winEnd) |=> $stable(state)); // R2
  AST_DISABLE_UNSYNC: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_UNSYNC && !stateChg)); // R1
  AST_STABLE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC && !stableEn) |=> (state != ST_STABLE)); // R7
  AST_SYNC_EXIT_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SYNC && !exitToUnsync) |=> (state != ST_UNSYNC || !$past(enable))); // R5
  AST_CHG_MEANS_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    stateChg |-> (state != $past(state))); // R12
  AST_CHG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    stateChg |=> !stateChg); // R12

endmodule

// File: rtl/clksync_state.sv
module clksync_state
  import clksync_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int CYC_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             winEnd,
  input  logic [CNT_W-1:0] inSchedCnt,
  input  logic [CNT_W-1:0] outSchedCnt,
  input  logic [CNT_W-1:0] syncTh,
  input  logic [CNT_W-1:0] syncExitTh,
  input  logic [CNT_W-1:0] stableExitTh,
  input  logic [CNT_W-1:0] stableTh,
  input  logic [CYC_W-1:0] supLimit,
  input  logic [CYC_W-1:0] lowLimit,
  input  logic             stableEn,
  input  logic             exitToUnsync,
  output logic [1:0]       state,
  output logic             stateChg
);

  cntCtrl_t   ctrl;
  syncState_t curState;
  logic       syncSupport, stableLow, syncExitHit, stableExitHit;
  logic       supDone, lowDone;
  logic [CYC_W-1:0] supRun, lowRun;

  clksync_dp #(.CNT_W(CNT_W), .CYC_W(CYC_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .inSchedCnt    (inSchedCnt),
    .outSchedCnt   (outSchedCnt),
    .syncTh        (syncTh),
    .syncExitTh    (syncExitTh),
    .stableExitTh  (stableExitTh),
    .stableTh      (stableTh),
    .supLimit      (supLimit),
    .lowLimit      (lowLimit),
    .syncSupport   (syncSupport),
    .stableLow     (stableLow),
    .syncExitHit   (syncExitHit),
    .stableExitHit (stableExitHit),
    .supDone       (supDone),
    .lowDone       (lowDone),
    .supRun        (supRun),
    .lowRun        (lowRun)
  );

  clksync_fsm uFsm (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .winEnd        (winEnd),
    .stableEn      (stableEn),
    .exitToUnsync  (exitToUnsync),
    .syncSupport   (syncSupport),
    .stableLow     (stableLow),
    .syncExitHit   (syncExitHit),
    .stableExitHit (stableExitHit),
    .supDone       (supDone),
    .lowDone       (lowDone),
    .state         (curState),
    .stateChg      (stateChg),
    .ctrl          (ctrl)
  );

  assign state = curState;

  AST_SUP_RUN_ONLY_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_SYNC) |-> (supRun == '0)); // R13
  AST_LOW_RUN_ONLY_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (curState != ST_STABLE) |-> (lowRun == '0)); // R13

endmodule

// File: tb/clksync_state_test.sv
module clksync_state_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       winEnd = 1'b0;
  logic [3:0] inSchedCnt = '0, outSchedCnt = '0;
  logic [3:0] syncTh = 4'd6, syncExitTh = 4'd13, stableExitTh = 4'd11, stableTh = 4'd8;
  logic [6:0] supLimit = 7'd2, lowLimit = 7'd1;
  logic       stableEn = 1'b1, exitToUnsync = 1'b0;
  logic [1:0] state;
  logic       stateChg;

  int checks = 0;
  int errors = 0;
  int mState = 0, mSup = 0, mLow = 0, expChg = 0;
  logic [15:0] lf = 16'hACE1;

  always #2.5 clk = ~clk;

  clksync_state uut (
    .clk(clk), .rstN(rstN), .enable(enable), .winEnd(winEnd),
    .inSchedCnt(inSchedCnt), .outSchedCnt(outSchedCnt),
    .syncTh(syncTh), .syncExitTh(syncExitTh), .stableExitTh(stableExitTh),
    .stableTh(stableTh), .supLimit(supLimit), .lowLimit(lowLimit),
    .stableEn(stableEn), .exitToUnsync(exitToUnsync),
    .state(state), .stateChg(stateChg)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // requirement-level model of one window end
  task automatic modelStep(int inC, int outC, output string tag);
    int ns;
    ns = mState;
    tag = "R2";
    case (mState)
      0: begin ns = 1; tag = "R3"; end
      1: begin tag = "R4"; if (inC >= int'(syncTh)) ns = 2; end
      2: begin
        if (outC >= int'(syncExitTh)) begin
          ns = exitToUnsync ? 0 : 1; tag = "R5";
        end else if (inC >= int'(syncTh)) begin
          if (stableEn && mSup >= int'(supLimit)) begin ns = 3; tag = "R6"; end
          else begin
            if (mSup < 127) mSup++;
            tag = stableEn ? "R6" : "R7";
          end
        end else begin mSup = 0; tag = "R8"; end
      end
      default: begin
        if (outC >= int'(stableExitTh)) begin ns = 1; tag = "R9"; end
        else if (inC < int'(stableTh)) begin
          tag = "R10";
          if (mLow >= int'(lowLimit)) ns = 1;
          else if (mLow < 127) mLow++;
        end else begin mLow = 0; tag = "R11"; end
      end
    endcase
    expChg = (ns != mState) ? 1 : 0;
    if (ns != mState) begin mSup = 0; mLow = 0; end
    mState = ns;
  endtask

  task automatic window(int inC, int outC, string tagOv);
    string t;
    inSchedCnt = 4'(inC);
    outSchedCnt = 4'(outC);
    winEnd = 1'b1;
    modelStep(inC, outC, t);
    if (tagOv != "") t = tagOv;
    @(posedge clk);
    @(negedge clk);
    winEnd = 1'b0;
    check(t, int'(state), mState);
    check("R12", int'(stateChg), expChg);
    @(posedge clk);
    @(negedge clk);
    check("R2", int'(state), mState);
    check("R12", int'(stateChg), 0);
  endtask

  task automatic dropEnable();
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mState = 0; mSup = 0; mLow = 0;
    check("R1", int'(state), 0);
    check("R1", int'(stateChg), 0);
    enable = 1'b1;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(state), 0);
    check("R1", int'(stateChg), 0);
    rstN = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    check("R2", int'(state), 0);

    // directed walk
    window(0, 0, "R3");
    window(3, 0, "R4");
    window(6, 0, "R4");
    window(9, 0, "R6");
    window(2, 0, "R8");
    window(9, 0, "R8");
    window(9, 0, "R6");
    window(9, 0, "R6");
    check("R6", int'(state), 3);
    window(3, 0, "R10");
    window(8, 0, "R11");
    window(3, 0, "R11");
    window(3, 0, "R10");
    check("R10", int'(state), 1);
    window(6, 0, "R4");
    window(9, 0, "");
    window(0, 13, "R5");
    check("R5", int'(state), 1);
    window(6, 0, "");
    window(9, 0, "R13");
    window(9, 0, "R13");
    check("R13", int'(state), 2);
    window(9, 0, "R13");
    check("R13", int'(state), 3);
    window(15, 11, "R9");
    check("R9", int'(state), 1);
    exitToUnsync = 1'b1;
    window(6, 0, "");
    window(9, 15, "R5");
    check("R5", int'(state), 0);
    stableEn = 1'b0;
    window(0, 0, "");
    window(6, 0, "");
    for (int k = 0; k < 4; k++) window(9, 0, "R7");
    check("R7", int'(state), 2);
    dropEnable();
    supLimit = 7'd0;
    lowLimit = 7'd0;
    stableEn = 1'b1;
    window(0, 0, "");
    window(6, 0, "");
    window(6, 0, "R6");
    check("R6", int'(state), 3);
    window(7, 0, "R10");
    check("R10", int'(state), 1);

    // sweep over small configurations
    for (int ex = 0; ex < 2; ex++)
      for (int se = 0; se < 2; se++)
        for (int sl = 0; sl < 3; sl++)
          for (int ll = 0; ll < 3; ll++) begin
            enable = 1'b0;
            exitToUnsync = ex[0];
            stableEn = se[0];
            supLimit = 7'(sl);
            lowLimit = 7'(ll);
            dropEnable();
            for (int w = 0; w < 40; w++) begin
              int inC;
              lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
              inC = lf[8] ? int'(lf[3:0] | 4'h8) : int'(lf[3:0]);
              window(inC, int'(lf[7:4]), "");
            end
          end
    finishRun();
  end

endmodule